// File: doc/BRIEF.md
# Edge-Locked x48 Clock Multiplier

This block turns a slow reference pulse train into a square wave running at exactly 48 times the reference rate. Everything runs on one fast system clock. A period counter with a fixed-point reload value sets the length of each output half-period. The output flip-flop toggles each time the counter expires, so one reference period holds 96 expiries. The fractional bits of the reload value are carried from one half-period to the next. This makes the average output rate fine-grained, while any single edge sits at most one system clock away from its ideal position.

The output is divided by three and then by sixteen to form a one-cycle feedback pulse. The reference passes through a two-flop synchroniser and a rising-edge detector. A comparator then times the gap between the reference edge and the feedback edge. Only edges are used, so neither the reference pulse width nor the feedback pulse width matters.

Each phase measurement feeds a proportional-plus-integral update of the reload value. The integral part moves by a bounded step per measurement, and the result is clamped to configured limits. If a reference pulse is missing, no measurement is taken. The output then keeps its last rate, and the lock flag keeps its last value.

Top module: `ref_multiplier`

## Requirements
- R1: The reference is used only through its synchronised rising edges. The reference pulse width, from one clock to half a period, has no effect on lock or output rate.
- R2: Once locked, 48 output periods measured from one tick to the 48th following tick span one reference period, within 6 system clocks.
- R3: The feedback pulse lasts one cycle. It comes once every 48 output rising edges, produced by a divide-by-3 stage followed by a divide-by-16 stage.
- R4: The phase error is positive when the feedback edge lags the reference edge and negative when it leads, counted in system clocks. A comparator wait longer than one nominal reference half-period is dropped without a measurement.
- R5: Each output half-period lasts the integer part of the reload value, or one clock more when the fraction carries. Every half-period is at least the integer part of the minimum reload. While locked, two consecutive half-periods differ by at most 2 clocks.
- R6: `period_tick` is high for exactly one cycle per output period: the cycle in which `mult_out` has just risen, and no other.
- R7: The integral (frequency) word moves by no more than the step bound per measurement. The reload value stays within its minimum and maximum bounds, so the output is never slower than 96 maximum half-periods per 48 cycles.
- R8: `locked` rises after 8 consecutive measurements whose error magnitude is below the threshold. It falls one cycle after any measurement at or above the threshold.
- R9: While locked, a run of missing reference pulses leaves the output running at its last rate and leaves `locked` high.
- R10: During reset and on the first cycle after it, `mult_out`, `period_tick` and `locked` are 0. The reload value starts at its nominal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference pulse train, asynchronous |
| mult_out | output | 1 | Multiplied square wave |
| period_tick | output | 1 | One-cycle strobe at each rising edge of `mult_out` |
| locked | output | 1 | Lock indicator |

## Verification
A reference edge reaches the comparator three cycles after the pin changes. A phase measurement updates the reload value and the lock flag one cycle after the second edge of a pair. A new reload value affects only half-periods loaded after it. `mult_out` and `period_tick` change together, one cycle after the counter expires. For these reasons the bench never checks rates against a single edge. It lets each reference pattern run 40 periods before checking lock and rate, then measures over a whole feedback period. It checks the lock drop 20 cycles after the displaced reference pulse, well past the 4-cycle path. It counts flywheel ticks over a window that starts 5 cycles after the last real pulse.

// File: rtl/ref_multiplier.sv
module ref_multiplier #(
  parameter int RW       = 16,
  parameter int FRAC     = 8,
  parameter int NOM_FX   = 333333,
  parameter int MIN_FX   = 300000,
  parameter int MAX_FX   = 370000,
  parameter int KP_SH    = 7,
  parameter int KI_SH    = 10,
  parameter int STEP_FX  = 64,
  parameter int LOCK_TH  = 8,
  parameter int LOCK_RUN = 8,
  parameter int DIV_A    = 3,
  parameter int DIV_B    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic mult_out,
  output logic period_tick,
  output logic locked
);
  localparam int FW  = RW + FRAC;
  localparam int EW  = RW + 7;
  localparam int SW  = FW + EW + 2;
  localparam int NOM_INT = NOM_FX >> FRAC;
  localparam int AW  = (DIV_A > 1) ? $clog2(DIV_A) : 1;
  localparam int BW  = (DIV_B > 1) ? $clog2(DIV_B) : 1;
  localparam int LW  = $clog2(LOCK_RUN + 1);
  localparam logic [EW-1:0] WIN = EW'(DIV_A * DIV_B * NOM_INT);
  localparam logic signed [SW-1:0] MIN_S  = SW'(MIN_FX);
  localparam logic signed [SW-1:0] MAX_S  = SW'(MAX_FX);
  localparam logic signed [SW-1:0] STEP_S = SW'(STEP_FX);
  localparam logic [EW:0] TH = (EW+1)'(LOCK_TH);

  typedef enum logic [1:0] {PD_IDLE, PD_WAIT_FB, PD_WAIT_REF} pd_t;

  logic [2:0]       ref_sr;
  logic             ref_rise;
  logic [FW-1:0]    reload_q, integ_q;
  logic [FRAC-1:0]  frac_q;
  logic [FRAC:0]    frac_sum;
  logic [RW-1:0]    cnt_q;
  logic             roll, rise_evt;
  logic [AW-1:0]    d3_q;
  logic [BW-1:0]    d16_q;
  logic             fb_q;
  pd_t              pd_st;
  logic [EW-1:0]    pc_q;
  logic             meas_v;
  logic signed [EW:0] meas_e;
  logic [EW:0]      meas_mag;
  logic [LW-1:0]    run_q;

  always_ff @(posedge clk)
    if (!rst_n) ref_sr <= '0;
    else        ref_sr <= {ref_sr[1:0], ref_in};

  assign ref_rise = ref_sr[1] & ~ref_sr[2];

  assign frac_sum = {1'b0, frac_q} + {1'b0, reload_q[FRAC-1:0]};
  assign roll     = (cnt_q == '0);
  assign rise_evt = roll & ~mult_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= RW'(NOM_INT - 1);
      frac_q      <= '0;
      mult_out    <= 1'b0;
      period_tick <= 1'b0;
    end else begin
      period_tick <= rise_evt;
      if (roll) begin
        cnt_q    <= reload_q[FW-1:FRAC] + {{(RW-1){1'b0}}, frac_sum[FRAC]} - RW'(1);
        frac_q   <= frac_sum[FRAC-1:0];
        mult_out <= ~mult_out;
      end else begin
        cnt_q <= cnt_q - RW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d3_q  <= '0;
      d16_q <= '0;
      fb_q  <= 1'b0;
    end else begin
      fb_q <= 1'b0;
      if (rise_evt) begin
        if (d3_q == AW'(DIV_A - 1)) begin
          d3_q <= '0;
          if (d16_q == BW'(DIV_B - 1)) begin
            d16_q <= '0;
            fb_q  <= 1'b1;
          end else begin
            d16_q <= d16_q + BW'(1);
          end
        end else begin
          d3_q <= d3_q + AW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd_st  <= PD_IDLE;
      pc_q   <= '0;
      meas_v <= 1'b0;
      meas_e <= '0;
    end else begin
      meas_v <= 1'b0;
      case (pd_st)
        PD_IDLE: begin
          pc_q <= EW'(1);
          if (ref_rise && fb_q) begin
            meas_v <= 1'b1;
            meas_e <= '0;
          end else if (ref_rise) pd_st <= PD_WAIT_FB;
          else if (fb_q)         pd_st <= PD_WAIT_REF;
        end
        PD_WAIT_FB: begin
          if (fb_q) begin
            meas_v <= 1'b1;
            meas_e <= $signed({1'b0, pc_q});
            pd_st  <= PD_IDLE;
          end else if (ref_rise) pc_q <= EW'(1);
          else if (pc_q == WIN)  pd_st <= PD_IDLE;
          else                   pc_q <= pc_q + EW'(1);
        end
        PD_WAIT_REF: begin
          if (ref_rise) begin
            meas_v <= 1'b1;
            meas_e <= -$signed({1'b0, pc_q});
            pd_st  <= PD_IDLE;
          end else if (fb_q)     pc_q <= EW'(1);
          else if (pc_q == WIN)  pd_st <= PD_IDLE;
          else                   pc_q <= pc_q + EW'(1);
        end
        default: pd_st <= PD_IDLE;
      endcase
    end
  end

  function automatic logic signed [SW-1:0] clampv(input logic signed [SW-1:0] v,
                                                  input logic signed [SW-1:0] lo,
                                                  input logic signed [SW-1:0] hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  logic signed [SW-1:0] e_sc, p_term, i_raw, i_term, i_next, r_next;
  assign e_sc   = SW'(meas_e) <<< FRAC;
  assign p_term = e_sc >>> KP_SH;
  assign i_raw  = e_sc >>> KI_SH;
  assign i_term = clampv(i_raw, -STEP_S, STEP_S);
  assign i_next = clampv($signed({{(SW-FW){1'b0}}, integ_q}) - i_term, MIN_S, MAX_S);
  assign r_next = clampv(i_next - p_term, MIN_S, MAX_S);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ_q  <= FW'(NOM_FX);
      reload_q <= FW'(NOM_FX);
    end else if (meas_v) begin
      integ_q  <= FW'(i_next);
      reload_q <= FW'(r_next);
    end
  end

  assign meas_mag = meas_e[EW] ? EW'(-meas_e) : EW'(meas_e);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      locked <= 1'b0;
    end else if (meas_v) begin
      if (meas_mag < TH) begin
        if (run_q == LW'(LOCK_RUN - 1)) locked <= 1'b1;
        else                            run_q  <= run_q + LW'(1);
      end else begin
        run_q  <= '0;
        locked <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ref_multiplier_chk.sv
module ref_multiplier_chk #(
  parameter int FW = 24,
  parameter int EW = 23,
  parameter int FRAC = 8,
  parameter int MIN_FX = 0,
  parameter int MAX_FX = 0,
  parameter int STEP_FX = 0,
  parameter int LOCK_TH = 8
) (
  input logic clk,
  input logic rst_n,
  input logic mult_out,
  input logic period_tick,
  input logic locked,
  input logic fb_q,
  input logic meas_v,
  input logic signed [EW:0] meas_e,
  input logic [FW-1:0] reload_q,
  input logic [FW-1:0] integ_q
);
  localparam int MIN_INT = MIN_FX >> FRAC;
  logic [15:0] hc;
  always_ff @(posedge clk)
    if (!rst_n || mult_out != $past(mult_out)) hc <= '0;
    else if (hc != 16'hFFFF) hc <= hc + 16'd1;

  AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) period_tick |-> (mult_out && !$past(mult_out))); // R6
  AST_RISE_HAS_TICK: assert property (@(posedge clk) disable iff (!rst_n) $rose(mult_out) |-> period_tick); // R6
  AST_FB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fb_q |=> !fb_q); // R3
  AST_RELOAD_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n) (int'(reload_q) >= MIN_FX) && (int'(reload_q) <= MAX_FX)); // R7
  AST_INTEG_STEP: assert property (@(posedge clk) disable iff (!rst_n) meas_v |=> ((int'(integ_q) - int'($past(integ_q)) <= STEP_FX) && (int'($past(integ_q)) - int'(integ_q) <= STEP_FX))); // R7
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n) (meas_v && (meas_e >= LOCK_TH || meas_e <= -LOCK_TH)) |=> !locked); // R8
  AST_HALF_MIN: assert property (@(posedge clk) disable iff (!rst_n) (mult_out != $past(mult_out)) |-> (int'(hc) >= MIN_INT - 1)); // R5
endmodule

bind ref_multiplier ref_multiplier_chk #(
  .FW(FW), .EW(EW), .FRAC(FRAC), .MIN_FX(MIN_FX), .MAX_FX(MAX_FX),
  .STEP_FX(STEP_FX), .LOCK_TH(LOCK_TH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mult_out(mult_out), .period_tick(period_tick),
  .locked(locked), .fb_q(fb_q), .meas_v(meas_v), .meas_e(meas_e),
  .reload_q(reload_q), .integ_q(integ_q)
);

// File: tb/sim_ref_multiplier.sv
module sim_ref_multiplier;
  logic clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0;
  logic mult_out, period_tick, locked;
  always #10 clk = ~clk;

  ref_multiplier #(
    .RW(8), .FRAC(8), .NOM_FX(2048), .MIN_FX(1536), .MAX_FX(2560),
    .KP_SH(7), .KI_SH(10), .STEP_FX(32), .LOCK_TH(8), .LOCK_RUN(8),
    .DIV_A(3), .DIV_B(16)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
    .mult_out(mult_out), .period_tick(period_tick), .locked(locked)
  );

  int n_chk = 0, n_err = 0;
  int gen_period = 768, gen_width = 1, skip_n = 0, shift_n = 0, ref_count = 0;
  bit gen_on = 0, done = 0;

  // {reference period, pulse width}
  localparam int VEC [4][2] = '{'{768, 1}, '{776, 384}, '{760, 5}, '{800, 2}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    wait (gen_on);
    forever begin
      @(negedge clk);
      if (shift_n > 0) begin
        repeat (shift_n) @(negedge clk);
        shift_n = 0;
      end
      if (skip_n > 0) begin
        skip_n--;
        repeat (gen_period - 1) @(negedge clk);
      end else begin
        ref_in = 1'b1;
        ref_count++;
        repeat (gen_width) @(negedge clk);
        ref_in = 1'b0;
        repeat (gen_period - gen_width - 1) @(negedge clk);
      end
    end
  end

  task automatic wait_refs(input int n);
    int target = ref_count + n;
    while (ref_count < target) @(negedge clk);
  endtask

  task automatic measure(output int dur, output int dmax, output int rises, output int bad_tick);
    int n = 0, half = 0, prev = -1;
    logic last;
    dmax = 0; rises = 0; bad_tick = 0; dur = 0;
    do @(negedge clk); while (!period_tick);
    last = mult_out;
    while (n < 48) begin
      @(negedge clk);
      dur++; half++;
      if (period_tick && !(mult_out && !last)) bad_tick++;
      if (mult_out && !last) rises++;
      if (mult_out != last) begin
        if (prev >= 0 && ((half > prev) ? half - prev : prev - half) > dmax)
          dmax = (half > prev) ? half - prev : prev - half;
        prev = half; half = 0; last = mult_out;
      end
      if (period_tick) n++;
    end
  endtask

  initial begin
    int dur, dmax, rises, bad, ticks, t0;
    repeat (4) @(negedge clk);
    chk(mult_out == 0 && period_tick == 0, "R10 reset outputs", mult_out + 2*period_tick, 0);
    chk(locked == 0, "R10 reset lock", locked, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(locked == 0 && period_tick == 0, "R10 first cycle", locked + 2*period_tick, 0);
    gen_on = 1;

    for (int v = 0; v < 4; v++) begin
      gen_period = VEC[v][0];
      gen_width  = VEC[v][1];
      wait_refs(40);
      chk(locked == 1, "R8 lock after settling (R1 width independence)", locked, 1);
      measure(dur, dmax, rises, bad);
      chk(dur >= gen_period - 6 && dur <= gen_period + 6, "R2 48 periods span", dur, gen_period);
      chk(dmax <= 2, "R5 half-period spread", dmax, 2);
      chk(rises == 48 && bad == 0, "R6 ticks match rises", rises - 100*bad, 48);
    end

    // R9: three missing reference pulses
    wait_refs(1);
    skip_n = 3;
    repeat (5) @(negedge clk);
    ticks = 0;
    for (int c = 0; c < 4*gen_period - 15; c++) begin
      @(negedge clk);
      if (period_tick) ticks++;
    end
    chk(ticks >= 190 && ticks <= 193, "R9 flywheel tick count", ticks, 192);
    chk(locked == 1, "R9 lock held across gap", locked, 1);

    // R8 / R4: displaced reference edge
    wait_refs(5);
    chk(locked == 1, "R8 locked before displacement", locked, 1);
    shift_n = 200;
    t0 = ref_count;
    while (ref_count == t0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(locked == 0, "R8 R4 lock drops on late reference", locked, 0);

    // R7: reference too slow for the reload bound
    gen_period = 1200;
    gen_width = 1;
    wait_refs(22);
    measure(dur, dmax, rises, bad);
    chk(dur <= 960 && dur >= 576, "R7 output limited by max reload", dur, 960);
    chk(locked == 0, "R7 no lock beyond range", locked, 0);

    // R10: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(mult_out == 0 && period_tick == 0 && locked == 0, "R10 reset mid-run",
        mult_out + 2*period_tick + 4*locked, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mult_out == 0 && locked == 0, "R10 after mid-run reset", mult_out + 2*locked, 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 195000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) chk(0, "watchdog", cyc, 195000);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule